// File: doc/BRIEF.md
# Buffered Serial-Flash SPI Master

This block is a register-driven SPI master aimed at serial flash parts. Software fills a 32-bit command word and a 32-byte data buffer over a simple 32-bit register bus, programs three bit counts, then writes a start strobe. The engine runs one transaction with three phases in a fixed order. It shifts out command bits, then transmit bits drawn from the buffer, then it receives bits from the device and writes each one back into the same buffer.

The serial clock is the system clock divided by a programmable value. Only SPI mode 0 is produced: SCK idles low, MOSI moves on falling edges and MISO is sampled on rising edges. Each device has its own active-low chip select, driven straight from a software register. Software therefore keeps a device selected across several transactions and releases it once busy has cleared.

Register word indices (byte offset / 4) are part of the behaviour: 0 control/status, 1 command word, 2..9 data buffer words 0..7, 10 configuration, 11 phase counts, 14 chip-select enables.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, every readable register returns 0, SCK and MOSI are low and every chip select is high.
- R2: A write to word 0 with bit 8 set, while idle and with a nonzero total bit count, sets busy (word 0 bit 16) from the next cycle. Busy stays set until the falling SCK edge of the last bit, then clears.
- R3: With divider N in configuration bits [27:16], consecutive rising SCK edges are N+2 system cycles apart. SCK is high for floor((N+2)/2) cycles of each bit, low for the rest, and low whenever idle.
- R4: Phases run in the order command, transmit, receive, and a phase with a zero count is skipped. The number of SCK pulses equals the sum of the clamped counts. A start with all three counts zero produces no SCK pulse and no busy.
- R5: Command bits come from word 1, most significant byte first. Within a byte, bits go MSB first, or LSB first when configuration bit 3 is set.
- R6: Transmit bits take buffer bytes in ascending order. Byte b is bits [8(b%4)+7 : 8(b%4)] of buffer word b/4, and bit order within a byte follows configuration bit 3.
- R7: Each MISO bit, sampled at a rising SCK edge, is written into the buffer at the position a transmitted bit of the same index would use. Buffer bits beyond the received count keep their previous value.
- R8: MOSI changes only at a falling SCK edge or at the start of a transaction. It is low throughout the receive phase and while idle.
- R9: Bit i of word 14 drives chip select i low (active), from the cycle after the write.
- R10: While busy, writes to the command word, buffer, configuration and counts are ignored, and so is a further start strobe.
- R11: Count fields are in word 11: command [31:24], receive [20:12], transmit [8:0]. A command count above 32 acts as 32, and a transmit or receive count above 256 acts as 256.
- R12: Configuration bits 5 and 4, the clock polarity and phase selects, are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | Access is a write |
| bus_word | input | 4 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench uses the default parameters: two chip selects and a 12-bit divider field. It exercises the divider at 0, 3, 6 and 20, which covers the fastest two-cycle bit, odd periods with unequal halves and long periods. The long periods leave time to attempt writes and a second start while busy. The 9-bit count fields allow full-buffer transmits, partial receive bytes and counts past the clamp limits. Both bit orders are covered on the command, transmit and receive paths.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int BUF_WORDS = 8;
    localparam int BUF_BITS  = BUF_WORDS * 32;
    localparam int OPC_MAX   = 32;
    localparam int DATA_MAX  = BUF_BITS;
    localparam int CNT_W     = $clog2(DATA_MAX) + 1;
    localparam int BIDX_W    = $clog2(BUF_BITS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPC  = 2'd1,
        PH_TXD  = 2'd2,
        PH_RXD  = 2'd3
    } phase_e;

    // register word indices (byte offset / 4)
    localparam logic [3:0] W_CTRL = 4'd0;
    localparam logic [3:0] W_OPC  = 4'd1;
    localparam logic [3:0] W_BUF0 = 4'd2;
    localparam logic [3:0] W_MCFG = 4'd10;
    localparam logic [3:0] W_CNTS = 4'd11;
    localparam logic [3:0] W_CSEL = 4'd14;

    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;
    localparam int LSB_BIT   = 3;
    localparam int DIV_LSB   = 16;

    function automatic logic [2:0] bit_in_byte(input logic [2:0] j, input logic lsb_first);
        return lsb_first ? j : (3'd7 - j);
    endfunction

endpackage

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int PW = DIV_W + 1;

    logic [PW-1:0] per, hi_len, lo_len;
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        per    = {1'b0, div_i} + PW'(2);
        hi_len = per >> 1;
        lo_len = per - hi_len;
        rise_o = run_i && (cnt_q == lo_len - PW'(1));
        fall_o = run_i && (cnt_q == per - PW'(1));
        cnt_d  = '0;
        if (run_i && !fall_o) begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the bit counter never leaves the programmed period
    a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < per));

endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DIV_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid_i,
    input  logic                bus_write_i,
    input  logic [3:0]          bus_word_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic                busy_i,
    input  logic                rx_we_i,
    input  logic [BIDX_W-1:0]   rx_idx_i,
    input  logic                rx_val_i,
    output logic                start_o,
    output logic [31:0]         opcode_o,
    output logic [BUF_BITS-1:0] buf_o,
    output logic [DIV_W-1:0]    div_o,
    output logic                lsb_o,
    output logic [7:0]          ops_f_o,
    output logic [CNT_W-1:0]    tx_f_o,
    output logic [CNT_W-1:0]    rx_f_o,
    output logic [NUM_CS-1:0]   cs_n_o
);
    typedef struct packed {
        logic [31:0]         opcode;
        logic [BUF_BITS-1:0] dbuf;
        logic [DIV_W-1:0]    div;
        logic                lsb;
        logic [7:0]          ops;
        logic [CNT_W-1:0]    rxn;
        logic [CNT_W-1:0]    txn;
        logic [NUM_CS-1:0]   cs;
    } regs_t;

    regs_t q, d;
    logic  wr;

    always_comb begin
        wr      = bus_valid_i && bus_write_i;
        start_o = wr && (bus_word_i == W_CTRL) && bus_wdata_i[START_BIT];
        d       = q;
        if (wr && !busy_i) begin
            if (bus_word_i == W_OPC) d.opcode = bus_wdata_i;
            if (bus_word_i == W_MCFG) begin
                d.div = bus_wdata_i[DIV_LSB +: DIV_W];
                d.lsb = bus_wdata_i[LSB_BIT];
            end
            if (bus_word_i == W_CNTS) begin
                d.ops = bus_wdata_i[31:24];
                d.rxn = bus_wdata_i[12 +: CNT_W];
                d.txn = bus_wdata_i[0 +: CNT_W];
            end
            for (int w = 0; w < BUF_WORDS; w++) begin
                if (bus_word_i == W_BUF0 + 4'(w)) d.dbuf[32*w +: 32] = bus_wdata_i;
            end
        end
        if (wr && (bus_word_i == W_CSEL)) d.cs = bus_wdata_i[NUM_CS-1:0];
        if (rx_we_i) d.dbuf[rx_idx_i] = rx_val_i;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_word_i)
            W_CTRL: bus_rdata_o[BUSY_BIT] = busy_i;
            W_OPC:  bus_rdata_o = q.opcode;
            W_MCFG: begin
                bus_rdata_o[DIV_LSB +: DIV_W] = q.div;
                bus_rdata_o[LSB_BIT]          = q.lsb;
            end
            W_CNTS: begin
                bus_rdata_o[31:24]       = q.ops;
                bus_rdata_o[12 +: CNT_W] = q.rxn;
                bus_rdata_o[0 +: CNT_W]  = q.txn;
            end
            W_CSEL: bus_rdata_o[NUM_CS-1:0] = q.cs;
            default: begin
                for (int w = 0; w < BUF_WORDS; w++) begin
                    if (bus_word_i == W_BUF0 + 4'(w)) bus_rdata_o = q.dbuf[32*w +: 32];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign opcode_o = q.opcode;
    assign buf_o    = q.dbuf;
    assign div_o    = q.div;
    assign lsb_o    = q.lsb;
    assign ops_f_o  = q.ops;
    assign tx_f_o   = q.txn;
    assign rx_f_o   = q.rxn;
    assign cs_n_o   = ~q.cs;

    // R10: configuration is frozen across a busy cycle
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> ($stable(q.opcode) && $stable(q.div) && $stable(q.lsb)
                           && $stable(q.ops) && $stable(q.rxn) && $stable(q.txn)));

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [31:0]         opcode_i,
    input  logic [BUF_BITS-1:0] buf_i,
    input  logic                lsb_i,
    input  logic [7:0]          ops_f_i,
    input  logic [CNT_W-1:0]    tx_f_i,
    input  logic [CNT_W-1:0]    rx_f_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                miso_i,
    output logic                busy_o,
    output logic                sck_o,
    output logic                mosi_o,
    output logic                rx_we_o,
    output logic [BIDX_W-1:0]   rx_idx_o,
    output logic                rx_val_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] bitn;
        logic             sck;
        logic             mosi;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0] ops_c, tx_c, rx_c, cur_c;
    logic             any_bits;

    always_comb begin
        ops_c    = (ops_f_i > 8'(OPC_MAX)) ? CNT_W'(OPC_MAX) : CNT_W'(ops_f_i);
        tx_c     = (tx_f_i > CNT_W'(DATA_MAX)) ? CNT_W'(DATA_MAX) : tx_f_i;
        rx_c     = (rx_f_i > CNT_W'(DATA_MAX)) ? CNT_W'(DATA_MAX) : rx_f_i;
        any_bits = (ops_c != '0) || (tx_c != '0) || (rx_c != '0);
        case (q.phase)
            PH_OPC:  cur_c = ops_c;
            PH_TXD:  cur_c = tx_c;
            PH_RXD:  cur_c = rx_c;
            default: cur_c = '0;
        endcase
    end

    always_comb begin
        d        = q;
        rx_we_o  = 1'b0;
        rx_val_o = miso_i;
        rx_idx_o = {q.bitn[7:3], bit_in_byte(q.bitn[2:0], lsb_i)};
        if (q.phase == PH_IDLE) begin
            if (start_i && any_bits) begin
                d.bitn = '0;
                if (ops_c != '0)     d.phase = PH_OPC;
                else if (tx_c != '0) d.phase = PH_TXD;
                else                 d.phase = PH_RXD;
            end
        end else begin
            if (rise_i) begin
                d.sck = 1'b1;
                if (q.phase == PH_RXD) rx_we_o = 1'b1;
            end
            if (fall_i) begin
                d.sck = 1'b0;
                if (({1'b0, q.bitn} + 1'b1) == {1'b0, cur_c}) begin
                    d.bitn = '0;
                    case (q.phase)
                        PH_OPC:  d.phase = (tx_c != '0) ? PH_TXD : ((rx_c != '0) ? PH_RXD : PH_IDLE);
                        PH_TXD:  d.phase = (rx_c != '0) ? PH_RXD : PH_IDLE;
                        default: d.phase = PH_IDLE;
                    endcase
                end else begin
                    d.bitn = q.bitn + 1'b1;
                end
            end
        end
        case (d.phase)
            PH_OPC:  d.mosi = opcode_i[{~d.bitn[4:3], bit_in_byte(d.bitn[2:0], lsb_i)}];
            PH_TXD:  d.mosi = buf_i[{d.bitn[7:3], bit_in_byte(d.bitn[2:0], lsb_i)}];
            default: d.mosi = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: PH_IDLE, bitn: '0, sck: 1'b0, mosi: 1'b0};
        else        q <= d;
    end

    assign busy_o = (q.phase != PH_IDLE);
    assign sck_o  = q.sck;
    assign mosi_o = q.mosi;

    // R2: an accepted start raises busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && any_bits) |=> busy_o);
    // R3: SCK rests low while idle
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);
    // R8: MOSI only moves with a falling SCK edge inside a transaction
    a_r8_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$fell(sck_o)) |-> $stable(mosi_o));
    // R8: MOSI is low in the receive phase
    a_r8_rx_mosi_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_RXD) |-> !mosi_o);
    // R4: SCK pulses occur only inside a transaction
    a_r4_edge_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> busy_o);

endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
    import spi_eng_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [3:0]        bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic                start, busy, lsb, rise, fall;
    logic                rx_we, rx_val;
    logic [BIDX_W-1:0]   rx_idx;
    logic [31:0]         opcode;
    logic [BUF_BITS-1:0] dbuf;
    logic [DIV_W-1:0]    div;
    logic [7:0]          ops_f;
    logic [CNT_W-1:0]    tx_f, rx_f;

    spi_eng_regs #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_word_i(bus_word),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .busy_i(busy), .rx_we_i(rx_we), .rx_idx_i(rx_idx), .rx_val_i(rx_val),
        .start_o(start), .opcode_o(opcode), .buf_o(dbuf), .div_o(div), .lsb_o(lsb),
        .ops_f_o(ops_f), .tx_f_o(tx_f), .rx_f_o(rx_f), .cs_n_o(spi_cs_n)
    );

    spi_eng_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div),
        .rise_o(rise), .fall_o(fall)
    );

    spi_eng_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .opcode_i(opcode), .buf_i(dbuf), .lsb_i(lsb),
        .ops_f_i(ops_f), .tx_f_i(tx_f), .rx_f_i(rx_f),
        .rise_i(rise), .fall_i(fall), .miso_i(spi_miso),
        .busy_o(busy), .sck_o(spi_sck), .mosi_o(spi_mosi),
        .rx_we_o(rx_we), .rx_idx_o(rx_idx), .rx_val_o(rx_val)
    );

endmodule

// File: tb/spi_flash_engine_bench.sv
`timescale 1ns/1ps
module spi_flash_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [1:0]  spi_cs_n;

    always #2.5 clk = ~clk;

    spi_flash_engine u_spi_flash_engine (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    bit      exp_bit[$];
    string   exp_tag[$];
    int      exp_period = 2;
    bit      first_edge = 1;
    realtime t_rise = 0;
    int      sck_edges = 0;
    int      rx_ptr = 0;
    logic [1023:0] pat = '0;
    logic [7:0] mbuf [32];
    bit      cur_lsb;
    int      cur_ops, cur_tx, cur_rx;

    assign spi_miso = pat[rx_ptr[9:0]];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every rising SCK edge
    always @(posedge spi_sck) begin
        sck_edges++;
        rx_ptr++;
        if (!first_edge)
            check(int'(($realtime - t_rise) / 5.0) == exp_period, "R3",
                  int'(($realtime - t_rise) / 5.0), exp_period, "SCK period");
        first_edge = 0;
        t_rise = $realtime;
        if (exp_bit.size() == 0) begin
            check(0, "R4", sck_edges, 0, "SCK edge with nothing expected");
        end else begin
            automatic bit    e = exp_bit.pop_front();
            automatic string t = exp_tag.pop_front();
            check(spi_mosi === e, t, spi_mosi, e, "MOSI bit");
        end
    end

    always @(negedge spi_sck) begin
        check(int'(($realtime - t_rise) / 5.0) == exp_period / 2, "R3",
              int'(($realtime - t_rise) / 5.0), exp_period / 2, "SCK high time");
    end

    task automatic bus_wr(input logic [3:0] w, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_word = w; bus_wdata = v;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [3:0] w, output logic [31:0] v);
        @(negedge clk);
        bus_word = w;
        #1 v = bus_rdata;
    endtask

    task automatic load_buf(input int seed);
        for (int w = 0; w < 8; w++) begin
            automatic logic [31:0] v = 32'h9E37_79B9 * (w + 1) ^ (seed * 32'h0101_0101);
            bus_wr(4'(2 + w), v);
            for (int b = 0; b < 4; b++) mbuf[4*w + b] = v[8*b +: 8];
        end
    endtask

    task automatic xfer_start(input logic [31:0] opc, input int ops_f, input int tx_f,
                              input int rx_f, input bit lsb, input int div);
        bus_wr(4'd10, {4'b0, div[11:0], 12'b0, lsb, 3'b0});
        bus_wr(4'd1, opc);
        bus_wr(4'd11, {ops_f[7:0], 3'b0, rx_f[8:0], 3'b0, tx_f[8:0]});
        cur_lsb = lsb;
        cur_ops = (ops_f > 32) ? 32 : ops_f;
        cur_tx  = (tx_f > 256) ? 256 : tx_f;
        cur_rx  = (rx_f > 256) ? 256 : rx_f;
        for (int k = 0; k < cur_ops; k++) begin
            automatic int p = lsb ? (k % 8) : (7 - k % 8);
            exp_bit.push_back(opc[8 * (3 - k / 8) + p]);
            exp_tag.push_back((ops_f > 32) ? "R11" : "R5");
        end
        for (int k = 0; k < cur_tx; k++) begin
            automatic int p = lsb ? (k % 8) : (7 - k % 8);
            exp_bit.push_back(mbuf[k / 8][p]);
            exp_tag.push_back((tx_f > 256) ? "R11" : "R6");
        end
        for (int k = 0; k < cur_rx; k++) begin
            exp_bit.push_back(1'b0);
            exp_tag.push_back("R8");
        end
        for (int i = 0; i < 32; i++) pat[32*i +: 32] = $urandom;
        exp_period = div + 2;
        first_edge = 1;
        rx_ptr = 0;
        bus_wr(4'd0, 32'h0000_0100);
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n = 0;
        do begin
            bus_rd(4'd0, v);
            n++;
        end while (v[16] && n < 20000);
        check(exp_bit.size() == 0, "R4", exp_bit.size(), 0, "bits left in scoreboard");
        check(spi_mosi == 1'b0 && spi_sck == 1'b0, "R8", {spi_sck, spi_mosi}, 0, "idle SCK/MOSI");
    endtask

    task automatic check_rx();
        logic [31:0] v;
        for (int r = 0; r < cur_rx; r++) begin
            automatic int p = cur_lsb ? (r % 8) : (7 - r % 8);
            mbuf[r / 8][p] = pat[cur_ops + cur_tx + r];
        end
        for (int w = 0; w < 8; w++) begin
            bus_rd(4'(2 + w), v);
            check(v == {mbuf[4*w+3], mbuf[4*w+2], mbuf[4*w+1], mbuf[4*w]}, "R7", v,
                  {mbuf[4*w+3], mbuf[4*w+2], mbuf[4*w+1], mbuf[4*w]}, "buffer word");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "WATCHDOG", 0, 1, "run did not complete");
        finish_run();
    end

    initial begin
        logic [31:0] v, o0, c0, m0, b0;
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int w = 0; w < 16; w++) begin
            bus_rd(4'(w), v);
            check(v == 0, "R1", v, 0, "register after reset");
        end
        check(spi_cs_n == 2'b11 && spi_sck == 0 && spi_mosi == 0, "R1",
              {spi_cs_n, spi_sck, spi_mosi}, 32'hC, "pins after reset");
        for (int b = 0; b < 32; b++) mbuf[b] = 8'h00;

        // R9 chip selects
        bus_wr(4'd14, 32'h1);
        check(spi_cs_n == 2'b10, "R9", spi_cs_n, 2'b10, "select device 0");
        bus_wr(4'd14, 32'h2);
        check(spi_cs_n == 2'b01, "R9", spi_cs_n, 2'b01, "select device 1");

        // R12 polarity/phase bits not kept
        bus_wr(4'd10, 32'h0005_0038);
        bus_rd(4'd10, v);
        check(v == 32'h0005_0008, "R12", v, 32'h0005_0008, "configuration readback");

        // transaction A: MSB first, fastest clock, all three phases
        load_buf(1);
        xfer_start(32'h0B12_3456, 8, 24, 40, 0, 0);
        bus_rd(4'd0, v);
        check(v[16] == 1'b1, "R2", v, 32'h0001_0000, "busy after start");
        wait_done();
        check_rx();

        // transaction B: LSB first, odd period, command then partial receive byte
        xfer_start(32'hA5C3_0F81, 32, 0, 13, 1, 3);
        wait_done();
        check_rx();

        // transaction C: transmit only, even period, LSB first
        load_buf(2);
        xfer_start(32'h0, 0, 16, 0, 1, 6);
        wait_done();

        // R11 command count clamp
        xfer_start(32'hDEAD_BEEF, 40, 0, 0, 0, 0);
        wait_done();

        // R11 transmit clamp: whole buffer goes out
        load_buf(3);
        xfer_start(32'h0, 0, 300, 0, 0, 0);
        wait_done();

        // R7 full-buffer receive, MSB first
        xfer_start(32'h0, 0, 0, 256, 0, 0);
        wait_done();
        check_rx();

        // R4 all counts zero: no busy, no edges
        bus_wr(4'd11, 32'h0);
        e0 = sck_edges;
        bus_wr(4'd0, 32'h100);
        bus_rd(4'd0, v);
        check(v[16] == 1'b0, "R4", v, 0, "busy with zero counts");
        repeat (30) @(negedge clk);
        check(sck_edges == e0, "R4", sck_edges, e0, "edges with zero counts");

        // R10 writes and second start during busy
        xfer_start(32'h1357_9BDF, 32, 0, 0, 0, 20);
        bus_rd(4'd1, o0); bus_rd(4'd11, c0); bus_rd(4'd10, m0); bus_rd(4'd2, b0);
        bus_wr(4'd1, 32'hFFFF_FFFF);
        bus_wr(4'd11, 32'h2000_1010);
        bus_wr(4'd10, 32'h0FFF_0008);
        bus_wr(4'd2, ~b0);
        bus_wr(4'd0, 32'h100);
        wait_done();
        repeat (200) @(negedge clk);
        check(exp_bit.size() == 0 && spi_sck == 0, "R10", exp_bit.size(), 0, "second start ignored");
        bus_rd(4'd1, v);  check(v == o0, "R10", v, o0, "command word kept");
        bus_rd(4'd11, v); check(v == c0, "R10", v, c0, "counts kept");
        bus_rd(4'd10, v); check(v == m0, "R10", v, m0, "configuration kept");
        bus_rd(4'd2, v);  check(v == b0, "R10", v, b0, "buffer word kept");

        finish_run();
    end

endmodule